// File: doc/BRIEF.md
# Progressive Frame Sync Generator

This block produces vertical frame timing for a video encoder that scans a non-interlaced picture in either a 625-line or a 525-line raster. A pixel-rate enable advances a pixel counter across each line and a line counter across each frame. Three outputs come from that position: an active-low vertical sync strobe that opens each field, a field indicator, and an input window that tells upstream logic on which lines to present digital video bytes. Each frame holds two fields of unequal length. In the 625-line raster the sync strobe lasts two and a half lines, so it ends in the middle of a line. In the 525-line raster it lasts three whole lines.

The outputs are registered. Each enabled cycle moves the counters one pixel and loads the outputs with the decode of the position just entered. The mode input is sampled at reset and again on the enabled cycle that wraps the raster back to line 1, pixel 0. A change made at any other time waits for that point.

The output register is a small state machine whose phase is one of three states: PH_BLANK (sync high, window closed), PH_SYNC (sync low, window closed) and PH_ACTIVE (sync high, window open). A field bit travels with the phase. Its transitions are: blank-to-sync when the field's first sync pixel is entered, sync-to-blank when the last sync pixel is left, blank-to-active on the first pixel of the field's first active line, and active-to-blank after the last pixel of its last active line. Reset enters PH_BLANK with the field bit at 0. When the enable is low every state holds.

Top module: `prog_sync_gen`

## Requirements
- R1: A synchronous active-high reset puts the position at pixel 0 of line 1 and holds vsync_n=1, field=0, act_win=0. The first enabled cycle afterwards moves to pixel 1 of line 1.
- R2: While pix_en is 0, no output and no counter position changes, whatever mode_ntsc does.
- R3: With mode_ntsc=0 (625-line mode) a line is PAL_PIX pixels (default 864) and a frame is 625 lines. Lines 1–312 form field 1 (field=0) and lines 313–625 form field 2 (field=1).
- R4: In 625-line mode vsync_n is 0 from pixel 0 of line 1 through pixel PAL_PIX/2−1 of line 3, which is 2.5 lines. It is also 0 from pixel 0 of line 313 through pixel PAL_PIX/2−1 of line 315, so it rises mid-line. It is 1 at every other position.
- R5: In 625-line mode act_win is 1 on every pixel of lines 23–310 (288 lines) and lines 335–622, and 0 elsewhere.
- R6: With mode_ntsc=1 (525-line mode) a line is NTSC_PIX pixels (default 858) and a frame is 525 lines. Lines 4–265 form field 1 (field=0, 262 lines). Lines 266–525 and 1–3 form field 2 (field=1, 263 lines).
- R7: In 525-line mode vsync_n is 0 on every pixel of lines 4–6 and of lines 266–268, and 1 elsewhere.
- R8: In 525-line mode act_win is 1 on every pixel of lines 22–261 and lines 284–522, and 0 elsewhere.
- R9: field changes on the same enabled cycle on which vsync_n falls, including the wrap from line 625 back to line 1.
- R10: mode_ntsc takes effect only at reset or on the wrap from the last pixel of the last line to pixel 0 of line 1. The line length and decode of the running frame follow the previously sampled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate advance enable |
| mode_ntsc | input | 1 | 1 selects 525-line mode, 0 selects 625-line mode |
| vsync_n | output | 1 | Vertical sync strobe, active low |
| field | output | 1 | 0 in field 1, 1 in field 2 |
| act_win | output | 1 | High on lines where video input is expected |

## Verification
The bench steps each mode through every boundary on both sides. These are the sync fall and rise in each field, the first and last lines of both active windows, and the field boundary. A decoder off by one line or one pixel would open the window a line early or leave sync low for a line too long. A design that ended the 625-line sync on a line edge rather than at the half-line would show a wrong value at pixel PAL_PIX/2. The bench switches mode mid-frame and checks that a design which applied the change at once would break the running frame, and that one which never applied it would give the wrong field-1 sync in the next frame. The bench also checks a stall and a mid-frame reset, which a design with a free-running counter or a late reset would fail.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic [1:0] {
        PH_BLANK  = 2'd0,
        PH_SYNC   = 2'd1,
        PH_ACTIVE = 2'd2
    } vphase_e;

    typedef struct packed {
        vphase_e phase;
        logic    field;
    } vstate_t;

    typedef enum logic {
        MODE_625 = 1'b0,
        MODE_525 = 1'b1
    } vmode_e;

endpackage

// File: rtl/vsg_raster_cnt.sv
module vsg_raster_cnt
    import vsg_pkg::*;
#(
    parameter int PAL_PIX    = 864,
    parameter int NTSC_PIX   = 858,
    parameter int PAL_LINES  = 625,
    parameter int NTSC_LINES = 525,
    parameter int PW         = 10,
    parameter int LW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  vmode_e        mode_in,
    output vmode_e        nxt_mode,
    output logic [PW-1:0] nxt_pix,
    output logic [LW-1:0] nxt_line
);

    logic [PW-1:0] pix_q;
    logic [LW-1:0] line_q;
    vmode_e        mode_q;
    logic [PW-1:0] last_pix;
    logic [LW-1:0] last_line;
    logic          eol;
    logic          eof;

    always_comb begin
        last_pix  = (mode_q == MODE_525) ? PW'(NTSC_PIX - 1) : PW'(PAL_PIX - 1);
        last_line = (mode_q == MODE_525) ? LW'(NTSC_LINES)   : LW'(PAL_LINES);
        eol       = (pix_q == last_pix);
        eof       = eol && (line_q == last_line);
        nxt_pix   = eol ? '0 : pix_q + PW'(1);
        nxt_line  = eof ? LW'(1) : (eol ? line_q + LW'(1) : line_q);
        nxt_mode  = eof ? mode_in : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            line_q <= LW'(1);
            mode_q <= mode_in;
        end else if (pix_en) begin
            pix_q  <= nxt_pix;
            line_q <= nxt_line;
            mode_q <= nxt_mode;
        end
    end

    AST_PIX_BOUND: assert property (@(posedge clk) disable iff (rst)
        pix_q <= last_pix);  // R3

    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (line_q >= LW'(1)) && (line_q <= last_line));  // R6

    AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> (pix_q == '0) && (line_q == LW'(1)));  // R10

endmodule

// File: rtl/vsg_field_decode.sv
module vsg_field_decode
    import vsg_pkg::*;
#(
    parameter int LINE_PIX   = 864,
    parameter int F1_START   = 1,
    parameter int F2_START   = 313,
    parameter int SYNC_LINES = 2,
    parameter int SYNC_HALF  = 1,
    parameter int ACT1_FIRST = 23,
    parameter int ACT1_LAST  = 310,
    parameter int ACT2_FIRST = 335,
    parameter int ACT2_LAST  = 622,
    parameter int PW         = 10,
    parameter int LW         = 10
) (
    input  logic [PW-1:0] pix,
    input  logic [LW-1:0] line,
    output vstate_t       st
);

    localparam int HALF_PIX = LINE_PIX / 2;

    logic          in_f2;
    logic [LW-1:0] rel;
    logic          in_sync;
    logic          in_act;

    always_comb begin
        in_f2   = (line >= LW'(F2_START)) || (line < LW'(F1_START));
        rel     = line - (in_f2 ? LW'(F2_START) : LW'(F1_START));
        in_sync = (rel < LW'(SYNC_LINES)) ||
                  ((SYNC_HALF != 0) && (rel == LW'(SYNC_LINES)) && (pix < PW'(HALF_PIX)));
        in_act  = in_f2 ? ((line >= LW'(ACT2_FIRST)) && (line <= LW'(ACT2_LAST)))
                        : ((line >= LW'(ACT1_FIRST)) && (line <= LW'(ACT1_LAST)));
        st.field = in_f2;
        if (in_sync)      st.phase = PH_SYNC;
        else if (in_act)  st.phase = PH_ACTIVE;
        else              st.phase = PH_BLANK;
    end

endmodule

// File: rtl/prog_sync_gen.sv
module prog_sync_gen
    import vsg_pkg::*;
#(
    parameter int PAL_PIX         = 864,
    parameter int NTSC_PIX        = 858,
    parameter int PAL_LINES       = 625,
    parameter int NTSC_LINES      = 525,
    parameter int PAL_F2_LINE     = 313,
    parameter int PAL_SYNC_LINES  = 2,
    parameter int PAL_SYNC_HALF   = 1,
    parameter int PAL_ACT_LINES   = 288,
    parameter int PAL_ACT1_FIRST  = 23,
    parameter int PAL_ACT2_FIRST  = 335,
    parameter int NTSC_F1_LINE    = 4,
    parameter int NTSC_F2_LINE    = 266,
    parameter int NTSC_SYNC_LINES = 3,
    parameter int NTSC_SYNC_HALF  = 0,
    parameter int NTSC_ACT1_FIRST = 22,
    parameter int NTSC_ACT1_LAST  = 261,
    parameter int NTSC_ACT2_FIRST = 284,
    parameter int NTSC_ACT2_LAST  = 522
) (
    input  logic clk,
    input  logic rst,
    input  logic pix_en,
    input  logic mode_ntsc,
    output logic vsync_n,
    output logic field,
    output logic act_win
);

    localparam int MAX_PIX   = (PAL_PIX > NTSC_PIX) ? PAL_PIX : NTSC_PIX;
    localparam int MAX_LINES = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES;
    localparam int PW        = $clog2(MAX_PIX);
    localparam int LW        = $clog2(MAX_LINES + 1);
    localparam int PAL_SYNC_LEN  = PAL_SYNC_LINES * PAL_PIX + ((PAL_SYNC_HALF != 0) ? PAL_PIX / 2 : 0);
    localparam int NTSC_SYNC_LEN = NTSC_SYNC_LINES * NTSC_PIX + ((NTSC_SYNC_HALF != 0) ? NTSC_PIX / 2 : 0);
    localparam int MAX_SYNC  = (PAL_SYNC_LEN > NTSC_SYNC_LEN) ? PAL_SYNC_LEN : NTSC_SYNC_LEN;
    localparam int CW        = $clog2(MAX_SYNC + 2);

    vmode_e        mode_in;
    vmode_e        nxt_mode;
    logic [PW-1:0] nxt_pix;
    logic [LW-1:0] nxt_line;
    vstate_t       st_625;
    vstate_t       st_525;
    vstate_t       nxt_st;
    vstate_t       state_q;

    assign mode_in = mode_ntsc ? MODE_525 : MODE_625;

    vsg_raster_cnt #(
        .PAL_PIX(PAL_PIX), .NTSC_PIX(NTSC_PIX),
        .PAL_LINES(PAL_LINES), .NTSC_LINES(NTSC_LINES),
        .PW(PW), .LW(LW)
    ) cnt_i (
        .clk(clk), .rst(rst), .pix_en(pix_en), .mode_in(mode_in),
        .nxt_mode(nxt_mode), .nxt_pix(nxt_pix), .nxt_line(nxt_line)
    );

    vsg_field_decode #(
        .LINE_PIX(PAL_PIX), .F1_START(1), .F2_START(PAL_F2_LINE),
        .SYNC_LINES(PAL_SYNC_LINES), .SYNC_HALF(PAL_SYNC_HALF),
        .ACT1_FIRST(PAL_ACT1_FIRST), .ACT1_LAST(PAL_ACT1_FIRST + PAL_ACT_LINES - 1),
        .ACT2_FIRST(PAL_ACT2_FIRST), .ACT2_LAST(PAL_ACT2_FIRST + PAL_ACT_LINES - 1),
        .PW(PW), .LW(LW)
    ) dec625_i (
        .pix(nxt_pix), .line(nxt_line), .st(st_625)
    );

    vsg_field_decode #(
        .LINE_PIX(NTSC_PIX), .F1_START(NTSC_F1_LINE), .F2_START(NTSC_F2_LINE),
        .SYNC_LINES(NTSC_SYNC_LINES), .SYNC_HALF(NTSC_SYNC_HALF),
        .ACT1_FIRST(NTSC_ACT1_FIRST), .ACT1_LAST(NTSC_ACT1_LAST),
        .ACT2_FIRST(NTSC_ACT2_FIRST), .ACT2_LAST(NTSC_ACT2_LAST),
        .PW(PW), .LW(LW)
    ) dec525_i (
        .pix(nxt_pix), .line(nxt_line), .st(st_525)
    );

    assign nxt_st = (nxt_mode == MODE_525) ? st_525 : st_625;

    // State register: loads the phase of the position being entered.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{phase: PH_BLANK, field: 1'b0};
        end else if (pix_en) begin
            state_q <= nxt_st;
        end
    end

    // Output decode of the phase.
    always_comb begin
        field = state_q.field;
        unique case (state_q.phase)
            PH_SYNC: begin
                vsync_n = 1'b0;
                act_win = 1'b0;
            end
            PH_ACTIVE: begin
                vsync_n = 1'b1;
                act_win = 1'b1;
            end
            default: begin
                vsync_n = 1'b1;
                act_win = 1'b0;
            end
        endcase
    end

    // Support logic for the checks below.
    logic          seen_en;
    logic          pulse_ok;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_en  <= 1'b0;
            pulse_ok <= 1'b0;
            low_cnt  <= '0;
        end else begin
            if (pix_en) seen_en <= 1'b1;
            if (vsync_n) pulse_ok <= seen_en;
            if (vsync_n) low_cnt <= '0;
            else if (pix_en) low_cnt <= low_cnt + CW'(1);
        end
    end

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(vsync_n) && $stable(field) && $stable(act_win));  // R2

    AST_FIELD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        ($past(seen_en) && !$stable(field)) |-> $fell(vsync_n));  // R9

    AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(vsync_n) && pulse_ok) |->
            (low_cnt == ((nxt_mode == MODE_525) ? CW'(NTSC_SYNC_LEN) : CW'(PAL_SYNC_LEN))));  // R4

    AST_SYNC_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> !act_win);  // R7

endmodule

// File: tb/prog_sync_gen_tb.sv
module prog_sync_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T_PAL_PIX  = 16;
    localparam int T_NTSC_PIX = 14;
    localparam int NV = 33;

    // {mode, line, pixel, vsync_n, field, act_win}
    localparam int VEC [NV][6] = '{
        '{0,   1,  1, 0,0,0}, '{0,   3,  7, 0,0,0}, '{0,   3,  8, 1,0,0},
        '{0,  22, 15, 1,0,0}, '{0,  23,  0, 1,0,1}, '{0, 310, 15, 1,0,1},
        '{0, 311,  0, 1,0,0}, '{0, 312, 15, 1,0,0}, '{0, 313,  0, 0,1,0},
        '{0, 315,  7, 0,1,0}, '{0, 315,  8, 1,1,0}, '{0, 334, 15, 1,1,0},
        '{0, 335,  0, 1,1,1}, '{0, 622, 15, 1,1,1}, '{0, 623,  0, 1,1,0},
        '{0, 625, 15, 1,1,0},
        '{1,   2,  0, 1,1,0}, '{1,   3, 13, 1,1,0}, '{1,   4,  0, 0,0,0},
        '{1,   6, 13, 0,0,0}, '{1,   7,  0, 1,0,0}, '{1,  21, 13, 1,0,0},
        '{1,  22,  0, 1,0,1}, '{1, 261, 13, 1,0,1}, '{1, 262,  0, 1,0,0},
        '{1, 265, 13, 1,0,0}, '{1, 266,  0, 0,1,0}, '{1, 268, 13, 0,1,0},
        '{1, 269,  0, 1,1,0}, '{1, 283, 13, 1,1,0}, '{1, 284,  0, 1,1,1},
        '{1, 522, 13, 1,1,1}, '{1, 523,  0, 1,1,0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pix_en = 1'b0;
    logic mode_ntsc = 1'b0;
    logic vsync_n, field, act_win;

    int n_chk = 0;
    int n_bad = 0;
    int b_line = 1;
    int b_pix = 0;
    int b_mode = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prog_sync_gen #(.PAL_PIX(T_PAL_PIX), .NTSC_PIX(T_NTSC_PIX)) dut_i (
        .clk(clk), .rst(rst), .pix_en(pix_en), .mode_ntsc(mode_ntsc),
        .vsync_n(vsync_n), .field(field), .act_win(act_win)
    );

    task automatic check(input string tag, input int ev, input int ef, input int ea);
        n_chk++;
        if (vsync_n !== 1'(ev) || field !== 1'(ef) || act_win !== 1'(ea)) begin
            n_bad++;
            $display("FAIL %s at line %0d pix %0d: got vs=%0b fld=%0b act=%0b, expected vs=%0d fld=%0d act=%0d",
                     tag, b_line, b_pix, vsync_n, field, act_win, ev, ef, ea);
        end
    endtask

    task automatic tick(input logic en);
        pix_en = en;
        @(posedge clk);
        @(negedge clk);
        if (en) begin
            int lp, fl;
            lp = b_mode ? T_NTSC_PIX : T_PAL_PIX;
            fl = b_mode ? 525 : 625;
            if (b_pix == lp - 1) begin
                b_pix = 0;
                if (b_line == fl) begin
                    b_line = 1;
                    b_mode = int'(mode_ntsc);
                end else b_line++;
            end else b_pix++;
        end
    endtask

    task automatic do_reset(input int m);
        mode_ntsc = 1'(m);
        pix_en = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R1 reset", 1, 0, 0);
        rst = 1'b0;
        b_line = 1; b_pix = 0; b_mode = m;
    endtask

    task automatic goto(input int ln, input int px);
        for (int g = 0; g < 20000; g++) begin
            if (b_line == ln && b_pix == px) break;
            tick(1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish before timeout");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        int cur;
        cur = -1;
        @(negedge clk);
        // Table walk: R3 R4 R5 (625-line), R6 R7 R8 (525-line), R9 across both.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][0] != cur) begin
                cur = VEC[i][0];
                do_reset(cur);
            end
            goto(VEC[i][1], VEC[i][2]);
            check(cur == 0 ? "R3 R4 R5 R9" : "R6 R7 R8 R9", VEC[i][3], VEC[i][4], VEC[i][5]);
        end

        // R9: wrap from line 625 to line 1 drops sync and field together.
        do_reset(0);
        goto(625, 15);
        check("R9 pre-wrap", 1, 1, 0);
        tick(1'b1);
        check("R9 wrap", 0, 0, 0);

        // R2: stall before the field-2 boundary, toggling mode meanwhile.
        goto(312, 15);
        check("R2 before stall", 1, 0, 0);
        for (int k = 0; k < 6; k++) begin
            mode_ntsc = ~mode_ntsc;
            tick(1'b0);
        end
        mode_ntsc = 1'b0;
        tick(1'b0);
        check("R2 held", 1, 0, 0);
        tick(1'b1);
        check("R2 resume", 0, 1, 0);

        // R10: mode request mid-frame waits for the wrap.
        mode_ntsc = 1'b1;
        goto(315, 7);
        check("R10 old mode kept", 0, 1, 0);
        goto(315, 8);
        check("R10 old mode half line", 1, 1, 0);
        goto(625, 15);
        tick(1'b1);
        check("R10 new mode at wrap", 1, 1, 0);
        goto(4, 0);
        check("R10 new mode sync", 0, 0, 0);
        goto(6, 13);
        check("R10 new line length", 0, 0, 0);
        goto(7, 0);
        check("R10 new sync end", 1, 0, 0);

        // R1: reset in mid-frame, then first step lands on pixel 1 of line 1.
        goto(50, 0);
        check("R8 mid-window", 1, 0, 1);
        do_reset(0);
        tick(1'b1);
        check("R1 restart position", 0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule